// File: doc/BRIEF.md
# Tagged Associative Translation Buffer

This block caches recent virtual-to-physical page translations in a small, fully associative store. A lookup request carries a virtual address, the identifier of the address space it belongs to, and an access kind. All stored entries are compared with the request's page number and identifier in a single cycle. The registered response gives one of three outcomes. A hit returns the physical frame joined to the unchanged page offset. A miss tells an external table walker to fetch the translation. A protection fault means the tag matched but the entry's permissions forbid the access kind.

Each entry records its address-space identifier, so translations for several processes can live side by side and a context switch needs no flush. A compile-time mode drops the identifier from the match; in that mode a context-switch pulse empties the buffer instead. New translations arrive on a plain fill port. Two invalidation commands are provided: one clears everything, and one clears only the entries of a single identifier.

Lookup requests enter through a valid/ready handshake, and responses leave through another. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. While a response is waiting and `rsp_ready` is low, `req_ready` is low and the response holds steady. Fill, flush and context-switch pins are single-cycle commands with no handshake.

Top module: `xlate_buffer`

## Requirements
- R1: A lookup that matches no valid entry on page number (address bits 31:12) and identifier returns miss, with `rsp_paddr` = 0 and `rsp_perm` = 0.
- R2: A request accepted on edge k yields `rsp_valid` = 1 right after edge k. While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high.
- R3: On a permitted hit, `rsp_paddr` = {stored frame, request address bits 11:0} and `rsp_perm` = the entry's permission bits (bit0 read, bit1 write, bit2 execute).
- R4: With identifier tagging (default), the same page under a different identifier misses, and entries for distinct identifiers coexist and translate independently.
- R5: The access kind is 00 read, 01 write, 10 execute, and 11 is never permitted. A tag match whose permission bit is clear returns fault, with `rsp_paddr` = 0 and `rsp_perm` = the entry's bits.
- R6: A fill with no matching entry goes to the lowest-numbered invalid entry. When all 16 entries are valid, it goes to a round-robin pointer that is 0 after reset, advances by one after each such replacement, and wraps from 15 to 0.
- R7: A fill whose page and identifier match a valid entry overwrites that entry in place. Duplicates never form, and the pointer does not move.
- R8: `flush_all` invalidates every entry. `flush_id_en` invalidates only the entries whose identifier equals `flush_id`. Any flush in a cycle discards a fill in that same cycle.
- R9: A lookup accepted in the same cycle as a fill or flush sees the table as it was before that update.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.
- R11: After reset, all entries are invalid, `rsp_valid` is 0 and `req_ready` is 1.
- R12: `ctx_switch` empties the buffer when tagging is disabled and has no effect when tagging is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Address-space identifier of the request |
| req_acc | input | 2 | Access kind (00 read, 01 write, 10 execute, 11 none) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PFN_W+PAGE_BITS | Physical address on hit, else 0 |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Tag matched, access not permitted |
| rsp_perm | output | 3 | Permission bits of matching entry |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-PAGE_BITS | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | 3 | Permission bits to install |
| flush_all | input | 1 | Invalidate all entries |
| flush_id_en | input | 1 | Invalidate entries of one identifier |
| flush_id | input | ASID_W | Identifier to invalidate |
| ctx_switch | input | 1 | Context-switch pulse (clears only in untagged mode) |

## Verification
The bench goes after identifier aliasing. If the identifier were left out of the compare, two processes' entries for the same page would hit each other's frames, or a second fill would overwrite the first. The bench also drives replacement into the full state and past the wrap, where a pointer that moved on in-place updates, or that failed to wrap, evicts the wrong page. It places fills and flushes in the same cycle as lookups, where a design that bypassed the new state would report a hit one cycle early. It also holds back-pressure for several cycles, where a design that kept accepting requests would change a held response.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_t;

  localparam int PERM_W = 3;

  // permission bits: [0] read, [1] write, [2] execute
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input acc_t acc);
    case (acc)
      ACC_READ:  perm_allows = perm[0];
      ACC_WRITE: perm_allows = perm[1];
      ACC_EXEC:  perm_allows = perm[2];
      default:   perm_allows = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xlb_entry_array.sv
module xlb_entry_array
  import xlb_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter int ASID_W   = 8,
  parameter bit USE_ASID = 1'b1,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  output logic              wr_hit,
  output logic [IDX_W-1:0]  wr_hit_idx,
  input  logic              clr_all,
  input  logic              clr_id_en,
  input  logic [ASID_W-1:0] clr_id,
  output logic [ENTRIES-1:0] vld_vec
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] wr_match;

  assign vld_vec = vld_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic lk_id_ok, wr_id_ok;
    if (USE_ASID) begin : g_tag
      assign lk_id_ok = (asid_q[g] == lk_asid);
      assign wr_id_ok = (asid_q[g] == wr_asid);
    end else begin : g_notag
      assign lk_id_ok = 1'b1;
      assign wr_id_ok = 1'b1;
    end
    assign lk_match[g] = vld_q[g] && (vpn_q[g] == lk_vpn) && lk_id_ok;
    assign wr_match[g] = vld_q[g] && (vpn_q[g] == wr_vpn) && wr_id_ok;
  end

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end
  assign lk_hit = |lk_match;

  always_comb begin
    wr_hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_match[i]) wr_hit_idx = IDX_W'(i);
    end
  end
  assign wr_hit = |wr_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr_all) begin
      vld_q <= '0;
    end else if (clr_id_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (asid_q[i] == clr_id) vld_q[i] <= 1'b0;
      end
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr_all && !clr_id_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
      pfn_q[wr_idx]  <= wr_pfn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)) else $error("duplicate match"); // R7
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_q == '0)) else $error("clear left entries"); // R8
endmodule

// File: rtl/xlb_victim.sv
module xlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic               wr_go,
  input  logic               wr_hit,
  input  logic [IDX_W-1:0]   wr_hit_idx,
  output logic [IDX_W-1:0]   wr_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] low_free;
  logic             all_full;
  logic             use_rr;

  always_comb begin
    low_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_vec[i]) low_free = IDX_W'(i);
    end
  end

  assign all_full = &vld_vec;
  assign use_rr   = wr_go && !wr_hit && all_full;
  assign wr_idx   = wr_hit ? wr_hit_idx : (all_full ? rr_q : low_free);

  always_ff @(posedge clk) begin
    if (!rst_n)      rr_q <= '0;
    else if (use_rr) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  AST_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !wr_hit && !all_full) |-> !vld_vec[wr_idx]) else $error("victim busy"); // R6
  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    use_rr |=> (rr_q != $past(rr_q))) else $error("pointer stuck"); // R6
  AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_hit) |=> $stable(rr_q)) else $error("pointer moved on update"); // R7
endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer
  import xlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int ENTRIES   = 16,
  parameter bit USE_ASID  = 1'b1,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = PFN_W + PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [2:0]        rsp_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [2:0]        fill_perm,
  input  logic              flush_all,
  input  logic              flush_id_en,
  input  logic [ASID_W-1:0] flush_id,
  input  logic              ctx_switch
);
  logic               lk_hit;
  logic [PFN_W-1:0]   lk_pfn;
  logic [PERM_W-1:0]  lk_perm;
  logic               wr_hit;
  logic [IDX_W-1:0]   wr_hit_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRIES-1:0] vld_vec;
  logic               clr_all;
  logic               wr_go;
  logic               req_fire;
  logic               allowed;

  assign clr_all  = flush_all || (!USE_ASID && ctx_switch);
  assign wr_go    = fill_en && !clr_all && !flush_id_en;
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire = req_valid && req_ready;
  assign allowed  = perm_allows(lk_perm, acc_t'(req_acc));

  xlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .ASID_W(ASID_W), .USE_ASID(USE_ASID)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vaddr[VA_W-1:PAGE_BITS]), .lk_asid(req_asid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .wr_en(wr_go), .wr_idx(wr_idx), .wr_vpn(fill_vpn), .wr_asid(fill_asid),
    .wr_pfn(fill_pfn), .wr_perm(fill_perm),
    .wr_hit(wr_hit), .wr_hit_idx(wr_hit_idx),
    .clr_all(clr_all), .clr_id_en(flush_id_en), .clr_id(flush_id),
    .vld_vec(vld_vec)
  );

  xlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld_vec(vld_vec),
    .wr_go(wr_go), .wr_hit(wr_hit), .wr_hit_idx(wr_hit_idx),
    .wr_idx(wr_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= lk_hit && allowed;
      rsp_fault <= lk_hit && !allowed;
      rsp_miss  <= !lk_hit;
      rsp_paddr <= (lk_hit && allowed) ? {lk_pfn, req_vaddr[PAGE_BITS-1:0]} : '0;
      rsp_perm  <= lk_hit ? lk_perm : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)) else $error("outcome"); // R2
  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid) else $error("no response"); // R2
  AST_HOLD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)
      && $stable(rsp_miss) && $stable(rsp_fault) && $stable(rsp_perm))) else $error("held response moved"); // R10
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_paddr == '0 && rsp_perm == '0)) else $error("miss data"); // R1
endmodule

// File: tb/sim_xlate_buffer.sv
module sim_xlate_buffer;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 1, fill_en = 0, flush_all = 0, flush_id_en = 0, ctx_switch = 0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0, fill_asid = '0, flush_id = '0;
  logic [1:0]  req_acc = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;

  int n_tests = 0, n_fail = 0;

  xlate_buffer u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          mv [N];
  logic [19:0] mvpn [N];
  logic [7:0]  mid [N];
  logic [19:0] mpfn [N];
  logic [2:0]  mperm [N];
  int          mptr;
  bit          m_rv, m_hit, m_miss, m_fault;
  logic [31:0] m_pa;
  logic [2:0]  m_perm;

  function automatic int find(input logic [19:0] vpn, input logic [7:0] id);
    for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn && mid[i] == id) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[i]) mv[i] = 0;
      mptr = 0; m_rv = 0; m_hit = 0; m_miss = 0; m_fault = 0; m_pa = 0; m_perm = 0;
    end else begin
      if (req_valid && (!m_rv || rsp_ready)) begin
        int k;
        bit ok;
        k = find(req_vaddr[31:12], req_asid);
        m_rv = 1;
        if (k < 0) begin
          m_hit = 0; m_miss = 1; m_fault = 0; m_pa = 0; m_perm = 0;
        end else begin
          ok = (req_acc != 2'b11) && mperm[k][req_acc];
          m_hit = ok; m_miss = 0; m_fault = !ok; m_perm = mperm[k];
          m_pa = ok ? {mpfn[k], req_vaddr[11:0]} : 32'h0;
        end
      end else if (rsp_ready) begin
        m_rv = 0;
      end
      if (flush_all) begin
        foreach (mv[i]) mv[i] = 0;
      end else if (flush_id_en) begin
        foreach (mv[i]) if (mid[i] == flush_id) mv[i] = 0;
      end else if (fill_en) begin
        int k;
        k = find(fill_vpn, fill_asid);
        if (k < 0) begin
          for (int i = N - 1; i >= 0; i--) if (!mv[i]) k = i;
        end
        if (k < 0) begin
          k = mptr;
          mptr = (mptr + 1) % N;
        end
        mv[k] = 1; mvpn[k] = fill_vpn; mid[k] = fill_asid; mpfn[k] = fill_pfn; mperm[k] = fill_perm;
      end
    end
  end

  // per-cycle comparison, sampled away from both edges
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R10 req_ready", req_ready, !m_rv || rsp_ready);
      chk("R2 rsp_valid", rsp_valid, m_rv);
      if (m_rv) begin
        chk("R2 one outcome", {rsp_hit, rsp_miss, rsp_fault}, {m_hit, m_miss, m_fault});
        chk("R3 paddr", rsp_paddr, m_pa);
        chk("R5 perm", rsp_perm, m_perm);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [31:0] c_pa;
  logic [2:0]  c_perm;
  logic [2:0]  c_out; // {hit, miss, fault}

  task automatic lookup(input logic [31:0] va, input logic [7:0] id, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_asid = id; req_acc = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    c_pa = rsp_paddr; c_perm = rsp_perm; c_out = {rsp_hit, rsp_miss, rsp_fault};
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] id, input logic [19:0] pfn, input logic [2:0] p);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_asid = id; fill_pfn = pfn; fill_perm = p;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rsp_valid after reset", rsp_valid, 0);
    chk("R11 req_ready after reset", req_ready, 1);
    lookup(32'h1234_5678, 8'd1, 2'b00);
    chk("R11 empty after reset", c_out, 3'b010);
    chk("R1 miss paddr", c_pa, 0);

    // basic hit
    fill(20'h12345, 8'd1, 20'hABCDE, 3'b011);
    lookup(32'h1234_5678, 8'd1, 2'b00);
    chk("R3 hit flag", c_out, 3'b100);
    chk("R3 hit paddr", c_pa, 32'hABCD_E678);
    chk("R3 hit perm", c_perm, 3'b011);

    // identifier tagging
    lookup(32'h1234_5678, 8'd2, 2'b00);
    chk("R4 other id misses", c_out, 3'b010);
    fill(20'h12345, 8'd2, 20'h11111, 3'b111);
    lookup(32'h1234_5ABC, 8'd2, 2'b00);
    chk("R4 id2 paddr", c_pa, 32'h1111_1ABC);
    lookup(32'h1234_5ABC, 8'd1, 2'b01);
    chk("R4 id1 still own frame", c_pa, 32'hABCD_EABC);

    // protection
    lookup(32'h1234_5000, 8'd1, 2'b10);
    chk("R5 exec fault", c_out, 3'b001);
    chk("R5 fault paddr zero", c_pa, 0);
    chk("R5 fault perm", c_perm, 3'b011);
    lookup(32'h1234_5000, 8'd2, 2'b11);
    chk("R5 kind 11 faults", c_out, 3'b001);

    // in-place overwrite
    fill(20'h12345, 8'd1, 20'h22222, 3'b001);
    lookup(32'h1234_5678, 8'd1, 2'b00);
    chk("R7 overwritten frame", c_pa, 32'h2222_2678);

    // same-cycle fill and lookup
    @(negedge clk);
    req_valid = 1; req_vaddr = 32'h0004_2010; req_asid = 8'd1; req_acc = 2'b00;
    fill_en = 1; fill_vpn = 20'h00042; fill_asid = 8'd1; fill_pfn = 20'h00777; fill_perm = 3'b001;
    @(negedge clk);
    req_valid = 0; fill_en = 0;
    chk("R9 lookup sees old table", {rsp_hit, rsp_miss, rsp_fault}, 3'b010);
    lookup(32'h0004_2010, 8'd1, 2'b00);
    chk("R9 fill visible next", c_pa, 32'h0077_7010);

    // context switch ignored in tagged mode
    @(negedge clk); ctx_switch = 1; @(negedge clk); ctx_switch = 0;
    lookup(32'h0004_2010, 8'd1, 2'b00);
    chk("R12 ctx_switch no effect", c_out, 3'b100);

    // flush by identifier
    @(negedge clk); flush_id_en = 1; flush_id = 8'd2; @(negedge clk); flush_id_en = 0;
    lookup(32'h1234_5678, 8'd2, 2'b00);
    chk("R8 id flush removes", c_out, 3'b010);
    lookup(32'h1234_5678, 8'd1, 2'b00);
    chk("R8 id flush keeps others", c_out, 3'b100);

    // flush all with a fill in the same cycle
    @(negedge clk);
    flush_all = 1; fill_en = 1; fill_vpn = 20'h00099; fill_asid = 8'd1; fill_pfn = 20'h1; fill_perm = 3'b001;
    @(negedge clk); flush_all = 0; fill_en = 0;
    lookup(32'h1234_5678, 8'd1, 2'b00);
    chk("R8 flush all", c_out, 3'b010);
    lookup(32'h0009_9000, 8'd1, 2'b00);
    chk("R8 fill dropped under flush", c_out, 3'b010);

    // replacement: fill all 16, then overflow
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 8'd3, 20'h00200 + 20'(i), 3'b001);
    fill(20'h01000, 8'd3, 20'h03000, 3'b001);
    lookup(32'h0010_0000, 8'd3, 2'b00);
    chk("R6 pointer 0 evicted", c_out, 3'b010);
    lookup(32'h0010_1000, 8'd3, 2'b00);
    chk("R6 entry 1 kept", c_pa, 32'h0020_1000);
    for (int i = 1; i < N; i++) fill(20'h01000 + 20'(i), 8'd3, 20'h03000 + 20'(i), 3'b001);
    fill(20'h02000, 8'd3, 20'h04000, 3'b001);
    lookup(32'h0100_0000, 8'd3, 2'b00);
    chk("R6 wrap evicts entry 0", c_out, 3'b010);
    lookup(32'h0100_1000, 8'd3, 2'b00);
    chk("R6 entry 1 survives wrap", c_pa, 32'h0300_1000);
    lookup(32'h0200_0000, 8'd3, 2'b00);
    chk("R6 new entry present", c_pa, 32'h0400_0000);

    // back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = 32'h0100_2000; req_asid = 8'd3; req_acc = 2'b00;
    @(negedge clk);
    req_vaddr = 32'h0100_3000;
    chk("R10 ready low while held", req_ready, 0);
    c_pa = rsp_paddr;
    repeat (3) @(negedge clk);
    chk("R10 held paddr", rsp_paddr, c_pa);
    chk("R10 held valid", rsp_valid, 1);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 second request served", rsp_paddr, 32'h0300_3000);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule